// File: doc/BRIEF.md
# I2C Burst Buffer Pair with Threshold and Drain Requests

This block holds the data bytes of an I2C controller in two byte queues, one toward the bus (transmit) and one from the bus (receive). Software moves bytes through a small register port. The serial byte engine pushes received bytes and pops bytes to send. The engine also reports how many bytes of the current transfer are still to cross the bus. Each queue has its own programmable threshold, and software is asked to act only when a whole burst of that size can be moved.

Near the end of a transfer, fewer bytes than the threshold may be left. In that case a full burst never comes. A separate drain request then tells software to move the short remainder, and a buffer-status readout gives the size of that remainder. All request and error flags are sticky and are cleared by writing ones. Overrun of the receive queue and underflow of the transmit queue are also flagged. The serial protocol itself lives outside this block.

Top module: `i2c_burst_buffers`

## Requirements
- R1: After reset the status word, the configuration readback and the buffer-status readout are all zero, and both queues are empty.
- R2: A configuration write (address 0) stores the transmit threshold from bits 5:0 and the receive threshold from bits 13:8. All other readback bits are zero. A threshold of 0 behaves as 1, and a threshold above the queue depth (32 by default) behaves as the depth.
- R3: Writing 1 to configuration bit 6 empties the transmit queue, and writing 1 to bit 14 empties the receive queue. Each takes effect on the clock edge of the write. Neither bit is stored.
- R4: Each queue returns bytes in arrival order. A push into a full queue is dropped and leaves the stored bytes intact. A software pop of an empty receive queue changes nothing.
- R5: Transmit-ready (status bit 4) sets when the following condition becomes true: free space is at least the threshold, and the bytes software still owes are at least the threshold. The bytes owed are the engine's remaining count minus the transmit level, floored at 0.
- R6: Receive-ready (status bit 3) sets when the receive level reaches the threshold.
- R7: Transmit-drain (status bit 14) sets when the bytes owed become nonzero, below the threshold, and no more than the free space.
- R8: Receive-drain (status bit 13) sets when three things hold together: the engine's remaining count is zero, the receive level is nonzero, and the receive level is below the threshold.
- R9: The buffer-status readout gives the transmit bytes owed in bits 5:0 (saturated at 63) and the receive level in bits 13:8.
- R10: A status write (address 1) clears every flag whose bit is 1, and a 0 bit has no effect. A flag that sets in the same cycle as its clear stays set.
- R11: An engine push into a full receive queue sets the overrun flag, status bit 11.
- R12: An engine pop of an empty transmit queue while the remaining count is nonzero sets the underflow flag, status bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 configuration, 1 status clear, 2 transmit data |
| reg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Configuration readback (thresholds) |
| stat_rdata | output | 16 | Request and error flags |
| bufstat_rdata | output | 16 | Transmit bytes owed and receive level |
| sw_rx_pop | input | 1 | Software takes one received byte |
| sw_rx_data | output | 8 | Head of the receive queue |
| eng_tx_pop | input | 1 | Engine takes one byte to send |
| eng_tx_data | output | 8 | Head of the transmit queue |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_left | input | 16 | Bytes of the current transfer not yet moved on the bus |

## Verification
The in-line assertions watch the behaviours that hold on every cycle. A push into a full queue leaves the level unchanged, and a flush empties the queue on the next cycle. A write-one clear takes a flag down unless a set arrives with it, and a set is never lost. Every overrun or underflow event leaves its flag raised. Only the directed scenarios can show the rest. These cover byte order through each queue, the exact moment each ready and drain request appears as levels and remaining counts move, the saturation and clamping of the threshold fields, and the buffer-status values at the end of a transfer.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
  localparam int THR_W = 6;
  localparam int REG_W = 16;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_TXD  = 2'd2;

  localparam int CFG_TX_THR_LSB = 0;
  localparam int CFG_TX_FLUSH   = 6;
  localparam int CFG_RX_THR_LSB = 8;
  localparam int CFG_RX_FLUSH   = 14;

  localparam int ST_RXRDY = 3;
  localparam int ST_TXRDY = 4;
  localparam int ST_UDF   = 10;
  localparam int ST_OVR   = 11;
  localparam int ST_RXDRN = 13;
  localparam int ST_TXDRN = 14;

  localparam int NFLAG = 6;
  typedef enum logic [2:0] {
    F_TXRDY = 3'd0, F_RXRDY = 3'd1, F_TXDRN = 3'd2,
    F_RXDRN = 3'd3, F_OVR   = 3'd4, F_UDF   = 3'd5
  } flag_idx_e;
endpackage

// File: rtl/ibb_fifo.sv
module ibb_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             do_push, do_pop;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rd_q];
  assign level   = lvl_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + PTR_W'(1);
      if (do_pop)  rd_d = rd_q + PTR_W'(1);
      lvl_d = lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (full && push && !pop && !flush) |=> $stable(lvl_q)) else $error("full push moved level"); // R4

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
    flush |=> (lvl_q == '0)) else $error("flush left data"); // R3
endmodule

// File: rtl/ibb_watermark.sv
module ibb_watermark #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 16,
  parameter bit IS_TX = 1'b1,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CW    = CNT_W + 2
) (
  input  logic [LVL_W-1:0]      level,
  input  logic [ibb_pkg::THR_W-1:0] thr_field,
  input  logic [CNT_W-1:0]      eng_left,
  output logic                  ready_c,
  output logic                  drain_c,
  output logic [ibb_pkg::THR_W-1:0] show_cnt
);
  localparam logic [CW-1:0] SAT = CW'((1 << ibb_pkg::THR_W) - 1);

  logic [CW-1:0] thr_e, fld_e, lvl_e, rem_e, left_e, free_e, shown;

  always_comb begin
    fld_e = CW'(thr_field);
    lvl_e = CW'(level);
    rem_e = CW'(eng_left);
    if (fld_e == '0)                thr_e = CW'(1);
    else if (fld_e > CW'(DEPTH))    thr_e = CW'(DEPTH);
    else                            thr_e = fld_e;
    free_e = CW'(DEPTH) - lvl_e;
  end

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        left_e  = (rem_e > lvl_e) ? (rem_e - lvl_e) : '0;
        ready_c = (free_e >= thr_e) && (left_e >= thr_e);
        drain_c = (left_e != '0) && (left_e < thr_e) && (free_e >= left_e);
        shown   = left_e;
      end
    end else begin : g_rx
      always_comb begin
        left_e  = lvl_e;
        ready_c = (lvl_e >= thr_e);
        drain_c = (rem_e == '0) && (lvl_e != '0) && (lvl_e < thr_e);
        shown   = lvl_e;
      end
    end
  endgenerate

  assign show_cnt = (shown > SAT) ? SAT[ibb_pkg::THR_W-1:0] : shown[ibb_pkg::THR_W-1:0];
endmodule

// File: rtl/ibb_flag.sv
module ibb_flag #(
  parameter bit EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic cond,
  input  logic clr,
  output logic q
);
  logic cond_q, q_q, q_d, set;

  generate
    if (EDGE) begin : g_edge
      assign set = cond && !cond_q;
    end else begin : g_level
      assign set = cond;
    end
  endgenerate

  always_comb begin
    q_d = q_q;
    if (set)      q_d = 1'b1;
    else if (clr) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      q_q    <= 1'b0;
    end else begin
      cond_q <= cond;
      q_q    <= q_d;
    end
  end

  assign q = q_q;

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr && !set) |=> !q_q) else $error("clear ignored"); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    set |=> q_q) else $error("set lost"); // R10
endmodule

// File: rtl/i2c_burst_buffers.sv
module i2c_burst_buffers #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [1:0]              reg_addr,
  input  logic [ibb_pkg::REG_W-1:0] reg_wdata,
  output logic [ibb_pkg::REG_W-1:0] cfg_rdata,
  output logic [ibb_pkg::REG_W-1:0] stat_rdata,
  output logic [ibb_pkg::REG_W-1:0] bufstat_rdata,
  input  logic                    sw_rx_pop,
  output logic [DW-1:0]           sw_rx_data,
  input  logic                    eng_tx_pop,
  output logic [DW-1:0]           eng_tx_data,
  input  logic                    eng_rx_push,
  input  logic [DW-1:0]           eng_rx_data,
  input  logic [CNT_W-1:0]        eng_left
);
  import ibb_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic cfg_we, stat_we, txd_we;
  assign cfg_we  = reg_we && (reg_addr == ADDR_CFG);
  assign stat_we = reg_we && (reg_addr == ADDR_STAT);
  assign txd_we  = reg_we && (reg_addr == ADDR_TXD);

  logic [THR_W-1:0] tx_thr_q, tx_thr_d, rx_thr_q, rx_thr_d;
  logic             tx_flush, rx_flush;

  always_comb begin
    tx_thr_d = tx_thr_q;
    rx_thr_d = rx_thr_q;
    if (cfg_we) begin
      tx_thr_d = reg_wdata[CFG_TX_THR_LSB +: THR_W];
      rx_thr_d = reg_wdata[CFG_RX_THR_LSB +: THR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (cfg_we) begin
      tx_thr_q <= tx_thr_d;
      rx_thr_q <= rx_thr_d;
    end
  end

  assign tx_flush = cfg_we && reg_wdata[CFG_TX_FLUSH];
  assign rx_flush = cfg_we && reg_wdata[CFG_RX_FLUSH];

  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic             tx_full, tx_empty, rx_full, rx_empty;

  ibb_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_ni(rst_ni), .flush(tx_flush),
    .push(txd_we), .wdata(reg_wdata[DW-1:0]),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  ibb_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_ni(rst_ni), .flush(rx_flush),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(sw_rx_pop), .rdata(sw_rx_data),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  logic             tx_rdy_c, tx_drn_c, rx_rdy_c, rx_drn_c;
  logic [THR_W-1:0] tx_show, rx_show;

  ibb_watermark #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_txwm (
    .level(tx_lvl), .thr_field(tx_thr_q), .eng_left(eng_left),
    .ready_c(tx_rdy_c), .drain_c(tx_drn_c), .show_cnt(tx_show)
  );

  ibb_watermark #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rxwm (
    .level(rx_lvl), .thr_field(rx_thr_q), .eng_left(eng_left),
    .ready_c(rx_rdy_c), .drain_c(rx_drn_c), .show_cnt(rx_show)
  );

  logic ovr_evt, udf_evt;
  assign ovr_evt = eng_rx_push && rx_full;
  assign udf_evt = eng_tx_pop && tx_empty && (eng_left != '0);

  logic [NFLAG-1:0] f_cond, f_clr, f_q;

  always_comb begin
    f_cond          = '0;
    f_cond[F_TXRDY] = tx_rdy_c;
    f_cond[F_RXRDY] = rx_rdy_c;
    f_cond[F_TXDRN] = tx_drn_c;
    f_cond[F_RXDRN] = rx_drn_c;
    f_cond[F_OVR]   = ovr_evt;
    f_cond[F_UDF]   = udf_evt;
    f_clr          = '0;
    f_clr[F_TXRDY] = stat_we && reg_wdata[ST_TXRDY];
    f_clr[F_RXRDY] = stat_we && reg_wdata[ST_RXRDY];
    f_clr[F_TXDRN] = stat_we && reg_wdata[ST_TXDRN];
    f_clr[F_RXDRN] = stat_we && reg_wdata[ST_RXDRN];
    f_clr[F_OVR]   = stat_we && reg_wdata[ST_OVR];
    f_clr[F_UDF]   = stat_we && reg_wdata[ST_UDF];
  end

  generate
    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
      ibb_flag #(.EDGE(gi < 4)) u_flag (
        .clk(clk), .rst_ni(rst_ni), .cond(f_cond[gi]),
        .clr(f_clr[gi]), .q(f_q[gi])
      );
    end
  endgenerate

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[ST_TXRDY] = f_q[F_TXRDY];
    stat_rdata[ST_RXRDY] = f_q[F_RXRDY];
    stat_rdata[ST_TXDRN] = f_q[F_TXDRN];
    stat_rdata[ST_RXDRN] = f_q[F_RXDRN];
    stat_rdata[ST_OVR]   = f_q[F_OVR];
    stat_rdata[ST_UDF]   = f_q[F_UDF];
    cfg_rdata                                = '0;
    cfg_rdata[CFG_TX_THR_LSB +: THR_W]       = tx_thr_q;
    cfg_rdata[CFG_RX_THR_LSB +: THR_W]       = rx_thr_q;
    bufstat_rdata                            = '0;
    bufstat_rdata[CFG_TX_THR_LSB +: THR_W]   = tx_show;
    bufstat_rdata[CFG_RX_THR_LSB +: THR_W]   = rx_show;
  end

  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (eng_rx_push && rx_full) |=> stat_rdata[ST_OVR]) else $error("overrun missed"); // R11

  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (eng_tx_pop && tx_empty && (eng_left != '0)) |=> stat_rdata[ST_UDF]) else $error("underflow missed"); // R12

  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (sw_rx_pop && rx_empty && !eng_rx_push) |=> (rx_lvl == '0)) else $error("empty pop moved level"); // R4
endmodule

// File: tb/i2c_burst_buffers_bench.sv
module i2c_burst_buffers_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] cfg_rdata, stat_rdata, bufstat_rdata;
  logic        sw_rx_pop;
  logic [7:0]  sw_rx_data;
  logic        eng_tx_pop;
  logic [7:0]  eng_tx_data;
  logic        eng_rx_push;
  logic [7:0]  eng_rx_data;
  logic [15:0] eng_left;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_burst_buffers u_i2c_burst_buffers (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata),
    .bufstat_rdata(bufstat_rdata), .sw_rx_pop(sw_rx_pop), .sw_rx_data(sw_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_left(eng_left)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b, input bit dec);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = b;
    if (dec) eng_left = eng_left - 16'd1;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic eng_pop_chk(input string req, input logic [7:0] exp, input bit dec);
    @(negedge clk);
    check(req, {8'h00, eng_tx_data}, {8'h00, exp});
    eng_tx_pop = 1'b1;
    if (dec) eng_left = eng_left - 16'd1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic sw_pop_chk(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, {8'h00, sw_rx_data}, {8'h00, exp});
    sw_rx_pop = 1'b1;
    @(negedge clk);
    sw_rx_pop = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status", stat_rdata, 16'h0000);
    check("R1 cfg", cfg_rdata, 16'h0000);
    check("R1 bufstat", bufstat_rdata, 16'h0000);
  endtask

  task automatic t_cfg();
    wr(2'd0, 16'h0A05);
    check("R2 cfg fields", cfg_rdata, 16'h0A05);
    wr(2'd0, 16'hFFFF);
    check("R2 R3 unused and flush bits read zero", cfg_rdata, 16'h3F3F);
  endtask

  task automatic t_tx_burst();
    wr(2'd0, 16'h0304);
    wr(2'd1, 16'hFFFF);
    eng_left = 16'd10;
    tick(2);
    check("R5 tx ready", stat_rdata & 16'h0010, 16'h0010);
    wr(2'd1, 16'h0000);
    tick(1);
    check("R10 zero write no effect", stat_rdata & 16'h0010, 16'h0010);
    wr(2'd1, 16'h0010);
    tick(1);
    check("R10 w1c clears", stat_rdata & 16'h0010, 16'h0000);
    for (int i = 0; i < 8; i++) wr(2'd2, 16'(8'hA0 + i));
    tick(2);
    check("R7 tx drain", stat_rdata & 16'h4000, 16'h4000);
    check("R9 tx owed", bufstat_rdata & 16'h003F, 16'd2);
    for (int i = 0; i < 8; i++) eng_pop_chk("R4 tx order", 8'(8'hA0 + i), 1'b1);
    check("R9 tx owed after pops", bufstat_rdata & 16'h003F, 16'd2);
  endtask

  task automatic t_tx_full_flush();
    eng_left = 16'd40;
    for (int i = 0; i < 33; i++) wr(2'd2, 16'(8'h40 + i));
    check("R4 R9 full push dropped", bufstat_rdata & 16'h003F, 16'd8);
    for (int i = 0; i < 32; i++) eng_pop_chk("R4 tx full order", 8'(8'h40 + i), 1'b1);
    for (int i = 0; i < 3; i++) wr(2'd2, 16'h0055);
    check("R9 owed before flush", bufstat_rdata & 16'h003F, 16'd5);
    wr(2'd0, 16'h0344);
    check("R3 tx flush", bufstat_rdata & 16'h003F, 16'd8);
    check("R3 flush bit not stored", cfg_rdata, 16'h0304);
  endtask

  task automatic t_underflow();
    eng_left = 16'd2;
    wr(2'd1, 16'hFFFF);
    @(negedge clk); eng_tx_pop = 1'b1;
    @(negedge clk); eng_tx_pop = 1'b0;
    check("R12 underflow", stat_rdata & 16'h0400, 16'h0400);
    check("R12 owed unchanged", bufstat_rdata & 16'h003F, 16'd2);
  endtask

  task automatic t_rx_burst();
    eng_left = 16'd5;
    wr(2'd1, 16'hFFFF);
    for (int i = 0; i < 3; i++) eng_push(8'(8'hC0 + i), 1'b1);
    tick(1);
    check("R6 rx ready", stat_rdata & 16'h2008, 16'h0008);
    check("R9 rx level", bufstat_rdata & 16'h3F00, 16'h0300);
    for (int i = 0; i < 3; i++) sw_pop_chk("R4 rx order", 8'(8'hC0 + i));
    wr(2'd1, 16'h0008);
    eng_push(8'hD0, 1'b1);
    eng_push(8'hD1, 1'b1);
    tick(1);
    check("R8 rx drain", stat_rdata & 16'h2008, 16'h2000);
    sw_pop_chk("R4 rx tail", 8'hD0);
    sw_pop_chk("R4 rx tail", 8'hD1);
    sw_rx_pop = 1'b1; tick(1); sw_rx_pop = 1'b0; tick(1);
    check("R4 empty pop ignored", bufstat_rdata & 16'h3F00, 16'h0000);
  endtask

  task automatic t_rx_overrun_flush();
    eng_left = 16'd0;
    wr(2'd1, 16'hFFFF);
    for (int i = 0; i < 33; i++) eng_push(8'(i), 1'b0);
    tick(1);
    check("R11 overrun", stat_rdata & 16'h0800, 16'h0800);
    check("R9 rx full level", bufstat_rdata & 16'h3F00, 16'h2000);
    for (int i = 0; i < 32; i++) sw_pop_chk("R4 rx kept after overrun", 8'(i));
    eng_push(8'h11, 1'b0);
    eng_push(8'h22, 1'b0);
    wr(2'd0, 16'h4304);
    check("R3 rx flush", bufstat_rdata & 16'h3F00, 16'h0000);
    check("R3 rx flush not stored", cfg_rdata, 16'h0304);
  endtask

  task automatic t_thr_limits();
    eng_left = 16'd0;
    wr(2'd0, 16'h003F);
    wr(2'd1, 16'hFFFF);
    eng_left = 16'd40;
    tick(2);
    check("R2 R5 tx threshold clamps to depth", stat_rdata & 16'h4010, 16'h0010);
    eng_left = 16'd0;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hFFFF);
    eng_push(8'h77, 1'b0);
    tick(1);
    check("R2 R6 zero threshold acts as one", stat_rdata & 16'h2008, 16'h0008);
    sw_pop_chk("R4 single byte", 8'h77);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    sw_rx_pop = 1'b0; eng_tx_pop = 1'b0; eng_rx_push = 1'b0;
    eng_rx_data = '0; eng_left = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_cfg();
    t_tx_burst();
    t_tx_full_flush();
    t_underflow();
    t_rx_burst();
    t_rx_overrun_flush();
    t_thr_limits();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule